// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit decides, cycle by cycle, whether a five-stage in-order pipeline should stall, bubble or squash. The stages are fetch, decode, execute, memory and writeback. It looks at three things: the source registers the decode-stage instruction reads, the destination register and load flag of the instruction in execute, and the outcome of a branch comparator that resolves in decode. From these it drives the write enables of the program counter and the fetch/decode register. It also drives a bubble insert into the decode/execute register, a squash of the fetch/decode register, and the redirect select for the program counter.

Fetch always follows the sequential path, so branches are predicted not taken. A taken branch in decode squashes the single wrong-path instruction in fetch, and the next fetch comes from the target. A load whose result is needed by the very next instruction costs one interlock cycle. Every other data dependence is covered by forwarding or by a register file that writes before it reads, and instruction and data memories are separate. Those cases therefore never stall.

A bubble is formed by clearing the valid and write-enable control bits of the decode/execute register. The instruction encoding is left as it is. The unit is purely combinational in its decisions. The clock and reset only qualify its built-in checks.

Top module: `hazard_ctrl`

## Requirements
- R1: When execute holds a valid load whose destination equals decode's first source register (`id_use_rs1`=1), `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1 in that same cycle.
- R2: The same interlock is raised for a match on the second source register when `id_use_rs2`=1. A match on a source whose use flag is 0 raises nothing.
- R3: A load destination of register 0 never raises the interlock.
- R4: A valid non-load producer in execute never stalls, whatever registers match: `pc_we`=1, `ifid_we`=1, `idex_bubble`=0.
- R5: A valid branch in decode with `br_taken`=1 and no interlock gives `ifid_flush`=1 and `pc_redirect`=1 while `pc_we` stays 1.
- R6: A branch with `br_taken`=0, or `br_taken`=1 on a non-branch, gives `ifid_flush`=0 and `pc_redirect`=0 and adds no stall.
- R7: If the interlock and a taken branch arise together, the interlock wins: `ifid_flush`=0, `pc_redirect`=0, `idex_bubble`=1.
- R8: An invalid decode slot or an invalid execute slot raises neither interlock nor flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, qualifies the internal checks only |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| br_taken | input | 1 | Comparator result for the branch in decode |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Clear valid and write enables entering execute |
| ifid_flush | output | 1 | Clear valid of the fetch/decode register |
| pc_redirect | output | 1 | Select branch target as next PC |

## Verification
Directed patterns pair a load producer with a match on each source separately. Each match is tried with its use flag on and off, and against register 0, which separates a correct match on each operand from one that ignores the use flags or the zero register. The same register matches are repeated with a non-load producer and with invalid slots, to show that only a load can stall. Taken, not-taken and non-branch cases are applied with and without a concurrent interlock, which exposes a wrong priority between squash and stall. A long run of pseudo-random inputs drawn from a small register range, so matches are frequent, is then compared every clock against a behavioural model.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             id_branch,
  input  logic             br_taken,
  input  logic             ex_valid,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic             ifid_flush,
  output logic             pc_redirect
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ld_producer, hit_rs1, hit_rs2, interlock, take;

  assign ld_producer = ex_valid && ex_load && (ex_rd != ZERO_REG);
  assign hit_rs1     = id_use_rs1 && (id_rs1 == ex_rd);
  assign hit_rs2     = id_use_rs2 && (id_rs2 == ex_rd);
  assign interlock   = id_valid && ld_producer && (hit_rs1 || hit_rs2);

  assign take        = id_valid && id_branch && br_taken && !interlock;

  assign pc_we       = !interlock;
  assign ifid_we     = !interlock;
  assign idex_bubble = interlock;
  assign ifid_flush  = take;
  assign pc_redirect = take;

  AST_BUBBLE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we)); // R1
  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO_REG) |-> !idex_bubble); // R3
  AST_NONLOAD_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> (pc_we && ifid_we && !idex_bubble)); // R4
  AST_FLUSH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (pc_we && pc_redirect)); // R5
  AST_NOT_TAKEN_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |-> (!ifid_flush && !pc_redirect)); // R6
  AST_STALL_BEATS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifid_flush && idex_bubble)); // R7
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid || !ex_valid) |-> !idex_bubble); // R8

endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  localparam int RW = 5;

  logic clk = 0, rst_n = 0;
  logic id_valid = 0, id_use_rs1 = 0, id_use_rs2 = 0, id_branch = 0, br_taken = 0;
  logic ex_valid = 0, ex_load = 0;
  logic [RW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0;
  logic pc_we, ifid_we, idex_bubble, ifid_flush, pc_redirect;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hazard_ctrl #(.REG_W(RW)) i_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_branch(id_branch),
    .br_taken(br_taken), .ex_valid(ex_valid), .ex_load(ex_load), .ex_rd(ex_rd),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .pc_redirect(pc_redirect));

  task automatic verify(input string req);
    bit stall, sq;
    logic [4:0] got, exp;
    stall = 0;
    if (ex_valid && ex_load && int'(ex_rd) != 0 && id_valid) begin
      if (id_use_rs1 && int'(id_rs1) == int'(ex_rd)) stall = 1;
      if (id_use_rs2 && int'(id_rs2) == int'(ex_rd)) stall = 1;
    end
    sq  = !stall && id_valid && id_branch && br_taken;
    exp = {!stall, !stall, stall, sq, sq};
    got = {pc_we, ifid_we, idex_bubble, ifid_flush, pc_redirect};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {pc_we,ifid_we,bubble,flush,redirect} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic put(input bit iv, input int r1, input int r2, input bit u1, input bit u2,
                     input bit br, input bit tk, input bit ev, input bit ld, input int rd,
                     input string req);
    @(negedge clk);
    id_valid = iv; id_rs1 = RW'(r1); id_rs2 = RW'(r2); id_use_rs1 = u1; id_use_rs2 = u2;
    id_branch = br; br_taken = tk; ex_valid = ev; ex_load = ld; ex_rd = RW'(rd);
    #1 verify(req);
  endtask

  initial begin
    #1 verify("reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    put(1, 3, 7, 1, 1, 0, 0, 1, 1, 3, "R1 load hits rs1");
    put(1, 3, 7, 1, 0, 0, 0, 1, 1, 7, "R2 rs2 unused no stall");
    put(1, 3, 7, 1, 1, 0, 0, 1, 1, 7, "R2 load hits rs2");
    put(1, 3, 7, 0, 1, 0, 0, 1, 1, 3, "R2 rs1 unused no stall");
    put(1, 0, 0, 1, 1, 0, 0, 1, 1, 0, "R3 zero register");
    put(1, 9, 9, 1, 1, 0, 0, 1, 0, 9, "R4 alu producer");
    put(1, 4, 5, 1, 1, 1, 1, 1, 0, 4, "R5 taken branch");
    put(1, 4, 5, 1, 1, 1, 0, 1, 0, 4, "R6 not taken");
    put(1, 4, 5, 1, 1, 0, 1, 0, 0, 0, "R6 taken flag on non-branch");
    put(1, 4, 5, 1, 1, 1, 1, 1, 1, 5, "R7 stall beats branch");
    put(1, 4, 5, 1, 1, 1, 1, 1, 1, 9, "R5 taken after load resolved");
    put(0, 6, 6, 1, 1, 1, 1, 1, 1, 6, "R8 empty decode");
    put(1, 6, 6, 1, 1, 0, 0, 0, 1, 6, "R8 empty execute");
    for (int n = 0; n < 400; n++)
      put($urandom_range(1), $urandom_range(3), $urandom_range(3), $urandom_range(1),
          $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1),
          $urandom_range(1), $urandom_range(3), "R1 R2 R3 R4 R5 R6 R7 R8 random");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule